// File: doc/BRIEF.md
# Dual Timer/Counter with Split Mode

This block holds two identical 16-bit timer/counters of the classic microcontroller kind, Timer 0 and Timer 1. Software reaches them through a small register port. One register picks, for each timer, the operating mode, the count source and gating. Another register holds the run bits and the overflow flags. Four more registers hold the count bytes. Each overflow flag drives its own interrupt request output.

A timer counts either the internal time base or falling edges on its event pin. The time base is the count clock enable divided by six. Four modes are available:
- a 13-bit counter;
- a 16-bit counter;
- an 8-bit counter with automatic reload from the high byte;
- a split mode.

In split mode, Timer 0 becomes two independent 8-bit timers. Its high half borrows Timer 1's run bit and overflow flag. If Timer 1 itself is put in split mode, its count freezes.

The register read port is combinational. A write takes effect at the next clock edge. All controls are plain level signals, with no handshake.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: Only cycles with `cnt_en` high are counted. Every sixth such cycle produces one time-base tick. A timer in timer mode advances by one on each tick.
- R3: Register addresses are as follows:
  - 0 is control: bit 4 run0, bit 5 flag0, bit 6 run1, bit 7 flag1, bits 3:0 read zero.
  - 1 is mode: bits 3:0 are Timer 0 and bits 7:4 are Timer 1. Within each nibble, the top bit is gate, the next bit is external-count and the low two bits are the mode.
  - 2 and 3 are the Timer 0 low and high bytes.
  - 4 and 5 are the Timer 1 low and high bytes.
  - Other addresses read zero.
  - A write to either count byte of a timer replaces that byte and blocks that timer's counting in that cycle.
- R4: With gate 0, the run bit alone enables a timer. With gate 1, the timer counts only while its run bit and its gate pin are both high.
- R5: With external-count 1, a timer advances on a tick where the event pin was high at the previous tick and is low now.
- R6: Mode 0 counts in the low 5 bits of the low byte and carries into the high byte. Low-byte bits 7:5 stay unchanged. Rolling over from all ones sets the flag.
- R7: Mode 1 is a 16-bit count. Rolling over from 0xFFFF to 0 sets the flag.
- R8: Mode 2 counts the low byte. On rollover the low byte loads the high byte and the flag sets.
- R9: In Timer 0 mode 3, the low byte is an 8-bit timer/counter governed by Timer 0's gate, source, run bit and flag.
- R10: In Timer 0 mode 3, the high byte counts ticks whenever run1 is set, regardless of gate or source, and its rollover sets flag1. Timer 1 overflows then do not set flag1.
- R11: Timer 1 in mode 3 holds its count unchanged.
- R12: A write to control sets or clears the flags. A hardware set in the same cycle wins, and `irq0`/`irq1` show flag0/flag1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| cnt_en | input | 1 | Timer input clock enable |
| ev0_pin | input | 1 | Timer 0 event input |
| ev1_pin | input | 1 | Timer 1 event input |
| gate0_pin | input | 1 | Timer 0 gate input |
| gate1_pin | input | 1 | Timer 1 gate input |
| irq0 | output | 1 | Timer 0 interrupt request (flag0) |
| irq1 | output | 1 | Timer 1 interrupt request (flag1) |

## Verification
The assertions assume that the event and gate pins are already synchronous to `clk`. They also assume that any count step they reason about does not share its cycle with a count-byte write. The step and reload properties are therefore conditioned on the absence of such a write.

The stimulus changes pins, enables and writes only on the falling clock edge, so every input is stable across the rising edge. Flag-collision writes are aimed at a cycle the reference model predicts to hold an overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    M_13BIT  = 2'd0,
    M_16BIT  = 2'd1,
    M_RELOAD = 2'd2,
    M_SPLIT  = 2'd3
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   ext;
    tmode_e mode;
  } tcfg_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_T0L  = 3'd2;
  localparam logic [2:0] A_T0H  = 3'd3;
  localparam logic [2:0] A_T1L  = 3'd4;
  localparam logic [2:0] A_T1H  = 3'd5;

  localparam int B_RUN0  = 4;
  localparam int B_FLAG0 = 5;
  localparam int B_RUN1  = 6;
  localparam int B_FLAG1 = 7;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  assign tick = clk_en && (pre == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre <= '0;
    else if (clk_en) pre <= tick ? '0 : pre + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit import tmr_pkg::*; #(
  parameter bit SPLIT = 1'b1,
  parameter int W     = BYTE_W,
  parameter int M0_LO = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ev_pin,
  input  logic         gate_pin,
  input  logic         run_bit,
  input  tcfg_t        cfg,
  input  logic         alt_run,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         ovf_main,
  output logic         ovf_alt
);
  localparam logic [M0_LO-1:0] LO_ONES = '1;

  logic         ev_q;
  logic         fall;
  logic         run;
  logic         step;
  logic         hold;
  logic [W-1:0] lo_n, hi_n;
  logic [2*W:0] sum16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ev_q <= 1'b0;
    else if (tick) ev_q <= ev_pin;
  end

  assign fall  = tick && ev_q && !ev_pin;
  assign run   = run_bit && (!cfg.gate || gate_pin);
  assign step  = run && (cfg.ext ? fall : tick);
  assign hold  = wr_lo || wr_hi;
  assign sum16 = {1'b0, cnt_hi, cnt_lo} + 1'b1;

  always_comb begin
    lo_n     = cnt_lo;
    hi_n     = cnt_hi;
    ovf_main = 1'b0;
    ovf_alt  = 1'b0;
    if (!hold) begin
      unique case (cfg.mode)
        M_13BIT: if (step) begin
          if (cnt_lo[M0_LO-1:0] == LO_ONES) begin
            lo_n[M0_LO-1:0] = '0;
            hi_n            = cnt_hi + 1'b1;
            ovf_main        = (cnt_hi == '1);
          end else begin
            lo_n[M0_LO-1:0] = cnt_lo[M0_LO-1:0] + 1'b1;
          end
        end
        M_16BIT: if (step) begin
          {hi_n, lo_n} = sum16[2*W-1:0];
          ovf_main     = sum16[2*W];
        end
        M_RELOAD: if (step) begin
          if (cnt_lo == '1) begin
            lo_n     = cnt_hi;
            ovf_main = 1'b1;
          end else begin
            lo_n = cnt_lo + 1'b1;
          end
        end
        M_SPLIT: if (SPLIT) begin
          if (step) begin
            lo_n     = cnt_lo + 1'b1;
            ovf_main = (cnt_lo == '1);
          end
          if (alt_run && tick) begin
            hi_n    = cnt_hi + 1'b1;
            ovf_alt = (cnt_hi == '1);
          end
        end
      endcase
    end
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= lo_n;
      cnt_hi <= hi_n;
    end
  end

  assert_step16_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == M_16BIT && !hold) |=>
      ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) ||
       {cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1));

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == M_RELOAD && !hold && ovf_main) |=> (cnt_lo == $past(cnt_hi)));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && cfg.mode != M_SPLIT && !hold) |=> $stable({cnt_hi, cnt_lo}));

  generate
    if (!SPLIT) begin : g_frozen
      assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == M_SPLIT && !hold) |=> $stable({cnt_hi, cnt_lo}));
    end
  endgenerate
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pkg::*; #(
  parameter int DIV = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cnt_en,
  input  logic       ev0_pin,
  input  logic       ev1_pin,
  input  logic       gate0_pin,
  input  logic       gate1_pin,
  output logic       irq0,
  output logic       irq1
);
  logic       tick;
  logic       run0, run1, flag0, flag1;
  logic [7:0] mode_q;
  tcfg_t      cfg0, cfg1;
  logic       split;
  logic       wr_ctrl, wr_mode;
  logic [7:0] t0_lo, t0_hi, t1_lo, t1_hi;
  logic       t0_main, t0_alt, t1_main, t1_alt;
  logic       set0, set1;

  assign cfg0    = tcfg_t'(mode_q[3:0]);
  assign cfg1    = tcfg_t'(mode_q[7:4]);
  assign split   = (cfg0.mode == M_SPLIT);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_mode = reg_wr && (reg_addr == A_MODE);

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clk_en(cnt_en), .tick(tick)
  );

  tmr_unit #(.SPLIT(1'b1)) u_t0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ev_pin(ev0_pin),
    .gate_pin(gate0_pin), .run_bit(run0), .cfg(cfg0), .alt_run(run1),
    .wr_lo(reg_wr && reg_addr == A_T0L), .wr_hi(reg_wr && reg_addr == A_T0H),
    .wdata(reg_wdata), .cnt_lo(t0_lo), .cnt_hi(t0_hi),
    .ovf_main(t0_main), .ovf_alt(t0_alt)
  );

  tmr_unit #(.SPLIT(1'b0)) u_t1 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ev_pin(ev1_pin),
    .gate_pin(gate1_pin), .run_bit(run1), .cfg(cfg1), .alt_run(1'b0),
    .wr_lo(reg_wr && reg_addr == A_T1L), .wr_hi(reg_wr && reg_addr == A_T1H),
    .wdata(reg_wdata), .cnt_lo(t1_lo), .cnt_hi(t1_hi),
    .ovf_main(t1_main), .ovf_alt(t1_alt)
  );

  assign set0 = t0_main;
  assign set1 = split ? t0_alt : (t1_main | t1_alt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run0   <= 1'b0;
      run1   <= 1'b0;
      flag0  <= 1'b0;
      flag1  <= 1'b0;
      mode_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run0 <= reg_wdata[B_RUN0];
        run1 <= reg_wdata[B_RUN1];
      end
      flag0 <= set0 | (wr_ctrl ? reg_wdata[B_FLAG0] : flag0);
      flag1 <= set1 | (wr_ctrl ? reg_wdata[B_FLAG1] : flag1);
      if (wr_mode) mode_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {flag1, run1, flag0, run0, 4'b0000};
      A_MODE:  reg_rdata = mode_q;
      A_T0L:   reg_rdata = t0_lo;
      A_T0H:   reg_rdata = t0_hi;
      A_T1L:   reg_rdata = t1_lo;
      A_T1H:   reg_rdata = t1_hi;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq0 = flag0;
  assign irq1 = flag1;

  assert_flag0_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set0 |=> irq0);
  assert_flag1_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set1 |=> irq1);
  assert_split_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !t0_alt && !wr_ctrl && !irq1) |=> !irq1);
endmodule

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
module tmr_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cnt_en = 1'b0;
  logic       ev0_pin = 1'b0, ev1_pin = 1'b0, gate0_pin = 1'b0, gate1_pin = 1'b0;
  logic       irq0, irq1;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  int    sweep = 0;
  bit    live = 0;

  always #5 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_en(cnt_en),
    .ev0_pin(ev0_pin), .ev1_pin(ev1_pin), .gate0_pin(gate0_pin),
    .gate1_pin(gate1_pin), .irq0(irq0), .irq1(irq1)
  );

  // Behavioural reference model
  int         m_pre;
  bit         m_p0, m_p1;
  logic [7:0] m_l0, m_h0, m_l1, m_h1, m_mode;
  bit         m_tr0, m_tf0, m_tr1, m_tf1;

  function automatic void adv(input bit inc, input logic [1:0] md,
                              inout logic [7:0] l, inout logic [7:0] h, inout bit o);
    int v;
    if (!inc) return;
    case (md)
      2'd0: if ((l & 8'h1F) == 8'h1F) begin
              o = (h == 8'hFF); l = l & 8'hE0; h = h + 8'd1;
            end else l = l + 8'd1;
      2'd1: begin
              v = h * 256 + l + 1; o = (v == 65536);
              l = v[7:0]; h = v[15:8];
            end
      2'd2: if (l == 8'hFF) begin l = h; o = 1; end else l = l + 8'd1;
      default: ;
    endcase
  endfunction

  task automatic model_step();
    bit tick, run0, run1, inc0, inc1, o0, oh, o1, s0, s1, hold0, hold1, wc;
    logic [7:0] nl0, nh0, nl1, nh1;
    tick = cnt_en && (m_pre == 5);
    run0 = m_tr0 && (!m_mode[3] || gate0_pin);
    run1 = m_tr1 && (!m_mode[7] || gate1_pin);
    inc0 = run0 && (m_mode[2] ? (tick && m_p0 && !ev0_pin) : tick);
    inc1 = run1 && (m_mode[6] ? (tick && m_p1 && !ev1_pin) : tick);
    hold0 = reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3);
    hold1 = reg_wr && (reg_addr == 3'd4 || reg_addr == 3'd5);
    nl0 = m_l0; nh0 = m_h0; nl1 = m_l1; nh1 = m_h1;
    o0 = 0; oh = 0; o1 = 0;
    if (!hold0) begin
      if (m_mode[1:0] == 2'd3) begin
        if (inc0) begin o0 = (m_l0 == 8'hFF); nl0 = m_l0 + 8'd1; end
        if (m_tr1 && tick) begin oh = (m_h0 == 8'hFF); nh0 = m_h0 + 8'd1; end
      end else adv(inc0, m_mode[1:0], nl0, nh0, o0);
    end
    if (!hold1) adv(inc1, m_mode[5:4], nl1, nh1, o1);
    if (reg_wr) case (reg_addr)
      3'd2: nl0 = reg_wdata;
      3'd3: nh0 = reg_wdata;
      3'd4: nl1 = reg_wdata;
      3'd5: nh1 = reg_wdata;
      default: ;
    endcase
    s0 = o0;
    s1 = (m_mode[1:0] == 2'd3) ? oh : o1;
    wc = reg_wr && reg_addr == 3'd0;
    m_tf0 = s0 | (wc ? reg_wdata[5] : m_tf0);
    m_tf1 = s1 | (wc ? reg_wdata[7] : m_tf1);
    if (wc) begin m_tr0 = reg_wdata[4]; m_tr1 = reg_wdata[6]; end
    if (reg_wr && reg_addr == 3'd1) m_mode = reg_wdata;
    if (tick) begin m_p0 = ev0_pin; m_p1 = ev1_pin; end
    if (cnt_en) m_pre = (m_pre == 5) ? 0 : m_pre + 1;
    m_l0 = nl0; m_h0 = nh0; m_l1 = nl1; m_h1 = nh1;
  endtask

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {m_tf1, m_tr1, m_tf0, m_tr0, 4'b0000};
      3'd1: return m_mode;
      3'd2: return m_l0;
      3'd3: return m_h0;
      3'd4: return m_l1;
      3'd5: return m_h1;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_p0 = 0; m_p1 = 0;
      m_l0 = 0; m_h0 = 0; m_l1 = 0; m_h1 = 0; m_mode = 0;
      m_tr0 = 0; m_tf0 = 0; m_tr1 = 0; m_tf1 = 0;
    end else model_step();
  end

  task automatic compare();
    logic [9:0] got, exp;
    if (!live) return;
    got = {irq1, irq0, reg_rdata};
    exp = {m_tf1, m_tf0, model_read(reg_addr)};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h at %0t", tag, reg_addr, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      reg_wr = 1'b0;
      reg_addr = 3'(sweep % 7);
      sweep++;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    compare();
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    tag = "R1"; idle(14);

    tag = "R3";
    wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'h56); wr(3'd5, 8'h78);
    wr(3'd1, 8'hA5); wr(3'd0, 8'hFF); idle(8);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); idle(8);

    tag = "R2";
    wr(3'd1, 8'h11); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h50);
    for (int i = 0; i < 300; i++) begin
      idle(1);
      cnt_en = (i % 3) != 1;
    end
    cnt_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      idle(1);
      if (i == 20) begin @(negedge clk); compare(); reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h40; end
    end

    tag = "R7";
    wr(3'd0, 8'h10); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF); idle(6 * 20);

    tag = "R12";
    wr(3'd0, 8'h10); idle(4);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      compare();
      if (m_pre == 5 && m_l0 == 8'hFF && m_h0 == 8'hFF) begin
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h10;
        break;
      end
      reg_wr = 1'b0; reg_addr = 3'd0;
    end
    idle(6);
    wr(3'd0, 8'h10); idle(4);

    tag = "R4";
    wr(3'd1, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    for (int i = 0; i < 400; i++) begin
      idle(1);
      gate0_pin = (i % 50) < 20;
    end
    wr(3'd0, 8'h00); idle(30);

    tag = "R5";
    wr(3'd1, 8'h05); wr(3'd2, 8'hFC); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
    for (int i = 0; i < 600; i++) begin
      idle(1);
      ev0_pin = (i % 26) < 13;
    end
    ev0_pin = 1'b0;

    tag = "R6";
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd4, 8'hFC); wr(3'd5, 8'hFF); wr(3'd0, 8'h40); idle(6 * 8);
    wr(3'd0, 8'h00); idle(4);

    tag = "R8";
    wr(3'd1, 8'h02); wr(3'd3, 8'hF8); wr(3'd2, 8'hFD); wr(3'd0, 8'h10);
    idle(6 * 30); wr(3'd0, 8'h00); idle(4);

    tag = "R9";
    wr(3'd1, 8'h13); wr(3'd2, 8'hFB); wr(3'd3, 8'hFD);
    wr(3'd4, 8'hF0); wr(3'd5, 8'hFF); wr(3'd0, 8'h10);
    idle(6 * 12);

    tag = "R10";
    wr(3'd0, 8'h50); gate0_pin = 1'b0;
    idle(6 * 30);
    wr(3'd1, 8'h1F); idle(6 * 40);

    tag = "R11";
    wr(3'd1, 8'h30); wr(3'd4, 8'h22); wr(3'd5, 8'h33); wr(3'd0, 8'h40);
    for (int i = 0; i < 120; i++) begin
      idle(1);
      ev1_pin = (i % 14) < 7;
      gate1_pin = i[2];
    end
    wr(3'd1, 8'h10); idle(6 * 10);

    live = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule